// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Generator

This block turns a fast clock into the timing strobes a serial transmitter or receiver needs. A source tick comes either from the block's own clock, so there is one tick per cycle, or from a pulse input driven by an external clock that has already been brought into this clock domain. The source tick runs through an optional fixed divide-by-16 prescaler and then through a programmable divide-by-(N+1) counter with a 12-bit divisor. The result is the divided strobe. In synchronous mode the divided strobe is also the bit strobe. In asynchronous mode an oversampling stage divides it again by 1, 8, 16 or 32 to make the bit strobe.

Both outputs are single-cycle clock-enable pulses in the clock domain of `clk`. The block makes no derived clock. Divisor, prescale, oversampling and mode settings go into a shadow copy. The shadow is loaded when the block starts and again at each terminal count of the divider, so a period that has already started always runs to its full length. In synchronous mode, a setting that would make the divided strobe faster than half the source rate is raised to that limit, and the block reports this on a flag.

Top module: `baud_clkgen`

## Requirements
- R1: With `src_sel`=0 the source ticks once per `clk` cycle. With `src_sel`=1 the source ticks only in cycles where `ext_tick` is high.
- R2: With `pre16`=1 the prescaler passes one source tick in 16. With `pre16`=0 it passes every source tick.
- R3: The period of `div_tick` is prescale×(`cd`+1) source ticks, where `cd` is a 12-bit value, so `cd`=4095 gives 4096 with prescale 1.
- R4: In asynchronous mode (`sync_mode`=0) the period of `bit_tick` is the `div_tick` period times the factor set by `os_sel`: 2'b00=1, 2'b01=8, 2'b10=16, 2'b11=32. Every `bit_tick` falls in a cycle where `div_tick` is high.
- R5: In synchronous mode (`sync_mode`=1) `bit_tick` is high in exactly the cycles where `div_tick` is high.
- R6: With `sync_mode`=1, `cd`=0 and `pre16`=0, the divisor is raised to 1. The `div_tick` period is then 2 source ticks and `clamp_flag` reads 1. For every other setting `clamp_flag` reads 0.
- R7: With the internal source, the first `div_tick` comes prescale×(effective `cd`+1) cycles after the clock edge that first samples `en`=1.
- R8: A new value of `cd`, `pre16`, `os_sel` or `sync_mode` takes effect only at the next `div_tick`. A period already under way keeps its old length.
- R9: While `en`=0 no strobe appears from the second cycle onward, and all counters clear. Enabling again restarts the timing of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal source |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low clears all counters |
| src_sel | input | 1 | 0 = internal source, 1 = external tick |
| ext_tick | input | 1 | External source pulse, already in the `clk` domain |
| pre16 | input | 1 | Enables the divide-by-16 prescaler |
| cd | input | 12 | Divisor N, divide by N+1 |
| os_sel | input | 2 | Oversampling code (00=1x, 01=8x, 10=16x, 11=32x) |
| sync_mode | input | 1 | 1 = bit strobe equals divided strobe |
| div_tick | output | 1 | Divided clock-enable pulse |
| bit_tick | output | 1 | Bit-rate strobe |
| clamp_flag | output | 1 | Synchronous half-rate clamp in effect |

## Verification
The bench measures the distance between successive pulses and the latency from enable for random and directed settings. This catches an off-by-one in the (N+1) count, which would show up as a period one prescaled tick short, and a wrong oversampling decode, which would give the wrong multiple. A divisor change made in the middle of a period must leave that period at its old length. A design that reloads at once would cut it short. The clamp case must give a period of 2 with the flag set. A design without the clamp would pulse every cycle. Disabling and enabling again must restart the latency from zero, which a design that keeps stale counter state would get wrong.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    OS_X1  = 2'b00,
    OS_X8  = 2'b01,
    OS_X16 = 2'b10,
    OS_X32 = 2'b11
  } os_sel_e;

  localparam int OS_CNT_W = 5;

  // Oversampling factor for a code, one bit wider than the counter.
  function automatic logic [OS_CNT_W:0] os_factor(os_sel_e s);
    case (s)
      OS_X8:   return (OS_CNT_W+1)'(8);
      OS_X16:  return (OS_CNT_W+1)'(16);
      OS_X32:  return (OS_CNT_W+1)'(32);
      default: return (OS_CNT_W+1)'(1);
    endcase
  endfunction

  // Synchronous output would run at the full source rate without this.
  function automatic logic needs_clamp(logic sync, logic pre, logic cd_zero);
    return sync & ~pre & cd_zero;
  endfunction

endpackage

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_in,
  input  logic bypass,
  output logic tick_out
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt;
  logic          wrap;

  assign wrap     = tick_in && (cnt == LAST);
  assign tick_out = bypass ? tick_in : wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || bypass)   cnt <= '0;
    else if (tick_in)         cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R1: only source ticks advance the prescaler
  p_hold_without_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick_in) |=> $stable(cnt));

endmodule

// File: rtl/bgen_divider.sv
module bgen_divider #(
  parameter int CD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick_in,
  input  logic [CD_W-1:0] limit,
  output logic            tick_out
);
  logic [CD_W-1:0] cnt;
  logic            term;

  assign term     = tick_in && (cnt == limit);
  assign tick_out = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (tick_in)  cnt <= term ? '0 : cnt + 1'b1;
  end

  // R3: the count never passes the loaded divisor
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt <= limit));

endmodule

// File: rtl/bgen_oversample.sv
module bgen_oversample
  import baud_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    div_tick,
  input  logic    sync,
  input  os_sel_e sel,
  output logic    bit_tick
);
  logic [OS_CNT_W-1:0] cnt;
  logic [OS_CNT_W:0]   last;
  logic                hit;

  assign last     = os_factor(sel) - 1'b1;
  assign hit      = ({1'b0, cnt} >= last);
  assign bit_tick = div_tick && (sync || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || sync) cnt <= '0;
    else if (div_tick)   cnt <= hit ? '0 : cnt + 1'b1;
  end

  // R4: oversampling count moves only on divided strobes
  p_os_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !div_tick) |=> $stable(cnt));

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_gen_pkg::*;
#(
  parameter int CD_W    = 12,
  parameter int PRE_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            src_sel,
  input  logic            ext_tick,
  input  logic            pre16,
  input  logic [CD_W-1:0] cd,
  input  logic [1:0]      os_sel,
  input  logic            sync_mode,
  output logic            div_tick,
  output logic            bit_tick,
  output logic            clamp_flag
);
  // shadow configuration, reloaded at start and at each divider terminal count
  logic            running;
  logic            pre_sh;
  logic [CD_W-1:0] cd_sh;
  os_sel_e         os_sh;
  logic            sync_sh;
  logic            clamp_sh;

  // named internal events
  logic src_tick;
  logic pre_tick;
  logic div_evt;
  logic bit_evt;
  logic reload;
  logic clamp_now;

  assign src_tick  = running && (src_sel ? ext_tick : 1'b1);
  assign reload    = en && (!running || div_evt);
  assign clamp_now = needs_clamp(sync_mode, pre16, (cd == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pre_sh   <= 1'b0;
      cd_sh    <= '0;
      os_sh    <= OS_X1;
      sync_sh  <= 1'b0;
      clamp_sh <= 1'b0;
    end else if (!en) begin
      running  <= 1'b0;
    end else if (reload) begin
      running  <= 1'b1;
      pre_sh   <= pre16;
      cd_sh    <= clamp_now ? CD_W'(1) : cd;
      os_sh    <= os_sel_e'(os_sel);
      sync_sh  <= sync_mode;
      clamp_sh <= clamp_now;
    end
  end

  bgen_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!running),
    .tick_in(src_tick), .bypass(!pre_sh), .tick_out(pre_tick)
  );

  bgen_divider #(.CD_W(CD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(!running),
    .tick_in(pre_tick), .limit(cd_sh), .tick_out(div_evt)
  );

  bgen_oversample u_os (
    .clk(clk), .rst_n(rst_n), .clr(!running),
    .div_tick(div_evt), .sync(sync_sh), .sel(os_sh), .bit_tick(bit_evt)
  );

  assign div_tick   = div_evt;
  assign bit_tick   = bit_evt;
  assign clamp_flag = clamp_sh;

  // R9: a low enable silences both strobes from the next cycle
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!div_tick && !bit_tick));

  // R8: shadow settings change only at a terminal count or start
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !div_evt) |=> ($stable(cd_sh) && $stable(pre_sh) && $stable(os_sh)));

  // R6: synchronous strobes never come back to back
  p_sync_half_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_evt && sync_sh) |=> (!div_evt || !sync_sh));

  // R4: a bit strobe always rides on a divided strobe
  p_bit_on_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |-> div_evt);

endmodule

// File: tb/baud_clkgen_bench.sv
module baud_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, src_sel = 1'b0, ext_tick = 1'b0, pre16 = 1'b0, sync_mode = 1'b0;
  logic [11:0] cd = '0;
  logic [1:0]  os_sel = '0;
  logic        div_tick, bit_tick, clamp_flag;

  int n_chk = 0, n_bad = 0, cyc = 0, ext_k = 0;

  baud_clkgen u_baud_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .ext_tick(ext_tick),
    .pre16(pre16), .cd(cd), .os_sel(os_sel), .sync_mode(sync_mode),
    .div_tick(div_tick), .bit_tick(bit_tick), .clamp_flag(clamp_flag)
  );

  always #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // external source: one pulse every ext_k cycles
  initial begin : ext_gen
    int c = 0;
    forever begin
      @(negedge clk);
      if (ext_k > 0) begin
        ext_tick = (c == ext_k - 1);
        c = (c >= ext_k - 1) ? 0 : c + 1;
      end else ext_tick = 1'b0;
    end
  end

  function automatic int fac(logic [1:0] o);
    return (o == 2'd1) ? 8 : (o == 2'd2) ? 16 : (o == 2'd3) ? 32 : 1;
  endfunction
  function automatic int div_per(logic pr, int c, logic sy, int k);
    int ec = (sy && !pr && c == 0) ? 1 : c;
    return ((k > 0) ? k : 1) * (pr ? 16 : 1) * (ec + 1);
  endfunction

  task automatic chk(logic ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_evt(logic want_bit, output int t, output logic other);
    t = -1; other = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk); #1;
      if (want_bit ? bit_tick : div_tick) begin
        t = cyc; other = want_bit ? div_tick : bit_tick; return;
      end
    end
  endtask

  task automatic run_cfg(logic s, logic pr, int c, logic [1:0] o, logic sy, int k);
    int c0, t1, t2, b1, b2, p, f;
    logic oth, quiet;
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1; if (div_tick || bit_tick) quiet = 1'b0; end
    chk(quiet, "R9 silent while disabled", quiet, 1);
    @(negedge clk);
    src_sel = s; pre16 = pr; cd = 12'(c); os_sel = o; sync_mode = sy; ext_k = s ? k : 0;
    en = 1'b1; c0 = cyc;
    p = div_per(pr, c, sy, s ? k : 0);
    f = sy ? 1 : fac(o);
    wait_evt(1'b0, t1, oth);
    if (!s) chk(t1 - c0 == p, "R7/R9 first divided strobe latency", t1 - c0, p);
    chk(clamp_flag == (sy && !pr && c == 0), "R6 clamp flag", clamp_flag, (sy && !pr && c == 0));
    if (sy) chk(oth == 1'b1, "R5 bit strobe with divided strobe", oth, 1);
    wait_evt(1'b0, t2, oth);
    chk(t2 - t1 == p, s ? "R1 external source period" : (pr ? "R2 prescaled period" : "R3 divided period"), t2 - t1, p);
    if (!sy) begin
      wait_evt(1'b1, b1, oth);
      chk(oth == 1'b1, "R4 bit strobe on divided strobe", oth, 1);
      wait_evt(1'b1, b2, oth);
      chk(b2 - b1 == p * f, "R4 bit period", b2 - b1, p * f);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int t1, t2, t3;
    logic oth;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1 chk(!div_tick && !bit_tick && !clamp_flag, "R9 reset state quiet", div_tick | bit_tick | clamp_flag, 0);
    @(negedge clk); rst_n = 1'b1;

    run_cfg(1'b0, 1'b0, 5, 2'd1, 1'b0, 0);      // R3 R4 8x
    run_cfg(1'b0, 1'b1, 2, 2'd2, 1'b0, 0);      // R2 16x
    run_cfg(1'b0, 1'b0, 0, 2'd0, 1'b1, 0);      // R6 clamp
    run_cfg(1'b0, 1'b0, 7, 2'd3, 1'b1, 0);      // R5 sync
    run_cfg(1'b1, 1'b0, 4, 2'd0, 1'b0, 3);      // R1 external
    run_cfg(1'b0, 1'b0, 4095, 2'd0, 1'b0, 0);   // R3 full width
    run_cfg(1'b0, 1'b0, 0, 2'd3, 1'b0, 0);      // R4 1-cycle division, 32x

    // R8: mid-period divisor change keeps the current period
    run_cfg(1'b0, 1'b0, 9, 2'd0, 1'b0, 0);
    wait_evt(1'b0, t1, oth);
    @(negedge clk); @(negedge clk); cd = 12'd2;
    wait_evt(1'b0, t2, oth);
    chk(t2 - t1 == 10, "R8 running period not shortened", t2 - t1, 10);
    wait_evt(1'b0, t3, oth);
    chk(t3 - t2 == 3, "R8 new divisor after terminal count", t3 - t2, 3);

    for (int r = 0; r < 6; r++) begin
      logic pr = ($urandom % 4) == 0;
      int   c  = $urandom % 16;
      logic [1:0] o = 2'($urandom % 4);
      logic sy = ($urandom % 3) == 0;
      run_cfg(1'b0, pr, c, o, sy, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule